// File: doc/BRIEF.md
# Interlace-Capable Display Timing Generator

This block produces the raster timing for one display channel: horizontal sync, vertical sync, a data-enable strobe, the current field and the current pixel and line positions. Software programs the block through a small synchronous register port. Each axis takes four interval lengths, and every length is written as the count minus one. Each line, and each field in the vertical direction, runs through sync, back porch, active and front porch in that order. The polarity of each sync output can be set on its own.

In interlaced mode the generator alternates two fields. Each field has its own vertical interval set. Software normally programs half the frame height as each field's active length. It also makes the second field's back porch one line longer by writing the first field's back-porch line count there without the minus-one adjustment. In progressive mode only the first set is used, and the field output stays at 0.

A sticky status bit is set at every frame end, and an interrupt output follows it when the mask bit is set. All timing, polarity and scan-mode settings are copied into working registers only at a frame start, so a frame that is already running keeps its shape. The enable bit acts at once.

Top module: `disp_timing_gen`

## Requirements
- R1: Horizontal lengths are stored as pixels minus one (address 1 sync, 2 back porch, 3 active, 4 front porch). Each line runs sync, back porch, active, front porch, and `hcnt_o` counts pixels from 0 at the first sync pixel.
- R2: Vertical lengths for the first field are stored as lines minus one (address 5 sync, 6 back porch, 7 active, 8 front porch). Each field runs sync, back porch, active, front porch in lines, and `vcnt_o` counts lines from 0 at the first sync line.
- R3: `de_o` is high only while the horizontal and the vertical position are both in their active intervals.
- R4: Control bit 2 makes `hsync_o` active low and control bit 3 makes `vsync_o` active low. When a bit is clear, that sync is active high. While the block is disabled, both syncs sit at their inactive level.
- R5: Control bit 1 selects interlaced scan. Fields then alternate and `field_o` toggles at each field end. The second field (`field_o`=1) uses the vertical set at addresses 9 to 12, in the same order as the first set. In progressive scan, `field_o` stays 0 and only the first set is used.
- R6: Control bit 0 enables the generator. While it is clear the counters hold at zero and `de_o` is low. Clearing it during a frame returns both counters to zero.
- R7: Status bit 0 at address 14 is set at every frame end. In progressive scan a frame end is the end of every field. In interlaced scan it is only the end of the second field.
- R8: `irq_o` is high when the status bit and mask bit 0 at address 13 are both set. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R9: Writes to the timing registers and to control bits 1 to 3 take effect at the next frame start, or at once while the block is disabled.
- R10: After reset both counters are zero, `field_o` is 0, the block is disabled, `irq_o` is low and the status reads 0.
- R11: Reading any register returns the last value written to it, zero-extended. Control is at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Register write data |
| rdata_o | output | DW | Register read data for `addr_i` |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Current field, 0 or 1 |
| hcnt_o | output | CW+2 | Pixel position within the line |
| vcnt_o | output | CW+2 | Line position within the field |
| irq_o | output | 1 | Masked frame interrupt |

## Verification
The generator is run on a 10-pixel line with a 6-line first field. It is sampled at the edges of each interval, which separates off-by-one errors in the minus-one encoding and in the phase order. An interlaced run adds a 7-line second field. That run shows that the second vertical set is selected, that the field output alternates, and that the frame-end status is raised only after the second field. A mid-frame change of the active width must leave the current frame untouched and widen the following one, which tests the frame-start copy. Polarity-low, disable-mid-frame and interrupt mask and clear sequences cover the remaining controls.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  localparam int NUM_TIM   = 12;
  localparam int TIM_H     = 0;
  localparam int TIM_V0    = 4;
  localparam int TIM_V1    = 8;
  localparam int OFS_ACT   = 2;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_TIM  = 1;
  localparam int ADDR_MASK = 13;
  localparam int ADDR_STAT = 14;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_INTL = 1;
  localparam int CTRL_HLOW = 2;
  localparam int CTRL_VLOW = 3;
endpackage

// File: rtl/tgen_axis.sv
module tgen_axis
  import tgen_pkg::*;
#(
  parameter int CW = 12,
  localparam int PW = CW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [CW-1:0] len_sync_i,
  input  logic [CW-1:0] len_back_i,
  input  logic [CW-1:0] len_act_i,
  input  logic [CW-1:0] len_front_i,
  output phase_e        phase_o,
  output logic [PW-1:0] pos_o,
  output logic          wrap_o
);
  phase_e        phase_q;
  logic [CW-1:0] seg_q, seg_len;
  logic [PW-1:0] pos_q;
  logic          seg_last;

  always_comb begin
    unique case (phase_q)
      PH_SYNC: seg_len = len_sync_i;
      PH_BACK: seg_len = len_back_i;
      PH_ACT:  seg_len = len_act_i;
      default: seg_len = len_front_i;
    endcase
  end

  assign seg_last = (seg_q == seg_len);
  assign wrap_o   = step_i && seg_last && (phase_q == PH_FRONT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SYNC;
      seg_q   <= '0;
      pos_q   <= '0;
    end else if (clear_i) begin
      phase_q <= PH_SYNC;
      seg_q   <= '0;
      pos_q   <= '0;
    end else if (step_i) begin
      if (seg_last) begin
        seg_q   <= '0;
        phase_q <= phase_e'(phase_q + 2'd1);
      end else begin
        seg_q <= seg_q + 1'b1;
      end
      pos_q <= wrap_o ? '0 : pos_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign pos_o   = pos_q;

  // R1
  wrap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (pos_q == '0) && (phase_q == PH_SYNC));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i) |=> $stable(pos_q));
endmodule

// File: rtl/tgen_regs.sv
module tgen_regs
  import tgen_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          load_i,
  input  logic          frame_end_i,
  output logic          en_o,
  output logic          intl_o,
  output logic          hlow_o,
  output logic          vlow_o,
  output logic [CW-1:0] tim_o [NUM_TIM],
  output logic          irq_o
);
  logic [3:0]    ctrl_q, ctrl_nxt, ctrl_sh;
  logic [CW-1:0] tim_q [NUM_TIM];
  logic [CW-1:0] tim_nxt [NUM_TIM];
  logic [CW-1:0] tim_sh [NUM_TIM];
  logic          mask_q, stat_q, stat_clr;

  always_comb begin
    ctrl_nxt = ctrl_q;
    tim_nxt  = tim_q;
    if (wr_en_i) begin
      if (addr_i == AW'(ADDR_CTRL)) ctrl_nxt = wdata_i[3:0];
      for (int i = 0; i < NUM_TIM; i++)
        if (addr_i == AW'(ADDR_TIM + i)) tim_nxt[i] = wdata_i[CW-1:0];
    end
  end

  assign stat_clr = wr_en_i && (addr_i == AW'(ADDR_STAT)) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      ctrl_sh <= '0;
      mask_q  <= 1'b0;
      stat_q  <= 1'b0;
      for (int i = 0; i < NUM_TIM; i++) begin
        tim_q[i]  <= '0;
        tim_sh[i] <= '0;
      end
    end else begin
      ctrl_q <= ctrl_nxt;
      tim_q  <= tim_nxt;
      // working copy follows the programmed value only at a frame start
      if (load_i) begin
        ctrl_sh <= ctrl_nxt;
        tim_sh  <= tim_nxt;
      end
      if (wr_en_i && addr_i == AW'(ADDR_MASK)) mask_q <= wdata_i[0];
      if (frame_end_i)   stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_CTRL)) rdata_o = DW'(ctrl_q);
    if (addr_i == AW'(ADDR_MASK)) rdata_o = DW'(mask_q);
    if (addr_i == AW'(ADDR_STAT)) rdata_o = DW'(stat_q);
    for (int i = 0; i < NUM_TIM; i++)
      if (addr_i == AW'(ADDR_TIM + i)) rdata_o = DW'(tim_q[i]);
  end

  assign en_o   = ctrl_q[CTRL_EN];
  assign intl_o = ctrl_sh[CTRL_INTL];
  assign hlow_o = ctrl_sh[CTRL_HLOW];
  assign vlow_o = ctrl_sh[CTRL_VLOW];
  assign tim_o  = tim_sh;
  assign irq_o  = stat_q && mask_q;

  // R8
  stat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !stat_clr) |=> stat_q);

  // R7
  stat_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q) |-> $past(frame_end_i));

  // R9
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(tim_sh[TIM_H + OFS_ACT]) && $stable(ctrl_sh));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import tgen_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          field_o,
  output logic [CW+1:0] hcnt_o,
  output logic [CW+1:0] vcnt_o,
  output logic          irq_o
);
  localparam int PW = CW + 2;

  logic          en, intl, hlow, vlow;
  logic [CW-1:0] tim [NUM_TIM];
  logic [CW-1:0] v_len [4];
  logic          h_wrap, v_wrap, frame_end, field_q;
  phase_e        h_ph, v_ph;
  logic [PW-1:0] h_pos, v_pos;

  assign frame_end = v_wrap && (!intl || field_q);

  tgen_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .load_i(!en || frame_end), .frame_end_i(frame_end),
    .en_o(en), .intl_o(intl), .hlow_o(hlow), .vlow_o(vlow),
    .tim_o(tim), .irq_o
  );

  for (genvar k = 0; k < 4; k++) begin : g_vsel
    assign v_len[k] = field_q ? tim[TIM_V1 + k] : tim[TIM_V0 + k];
  end

  tgen_axis #(.CW(CW)) u_h (
    .clk_i, .rst_ni, .clear_i(!en), .step_i(1'b1),
    .len_sync_i(tim[TIM_H]), .len_back_i(tim[TIM_H + 1]),
    .len_act_i(tim[TIM_H + 2]), .len_front_i(tim[TIM_H + 3]),
    .phase_o(h_ph), .pos_o(h_pos), .wrap_o(h_wrap)
  );

  tgen_axis #(.CW(CW)) u_v (
    .clk_i, .rst_ni, .clear_i(!en), .step_i(h_wrap),
    .len_sync_i(v_len[0]), .len_back_i(v_len[1]),
    .len_act_i(v_len[2]), .len_front_i(v_len[3]),
    .phase_o(v_ph), .pos_o(v_pos), .wrap_o(v_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     field_q <= 1'b0;
    else if (!en)    field_q <= 1'b0;
    else if (v_wrap) field_q <= intl && !field_q;
  end

  assign hsync_o = (en && h_ph == PH_SYNC) ^ hlow;
  assign vsync_o = (en && v_ph == PH_SYNC) ^ vlow;
  assign de_o    = en && (h_ph == PH_ACT) && (v_ph == PH_ACT);
  assign field_o = field_q;
  assign hcnt_o  = h_pos;
  assign vcnt_o  = v_pos;

  // R3
  de_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hcnt_o != '0) && (vcnt_o != '0));

  // R5
  frame_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> !field_o);

  // R6
  disable_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (hcnt_o == '0) && (vcnt_o == '0) && !field_o);
endmodule

// File: tb/disp_timing_gen_test.sv
module disp_timing_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          hsync, vsync, de, field, irq;
  logic [CW+1:0] hcnt, vcnt;

  int checks = 0;
  int errors = 0;
  int t = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  disp_timing_gen #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .hsync_o(hsync), .vsync_o(vsync),
    .de_o(de), .field_o(field), .hcnt_o(hcnt), .vcnt_o(vcnt), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at t=%0d: actual %0d expected %0d", req, t, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    t++;
  endtask

  task automatic go_to(input int n);
    while (t < n) tick();
  endtask

  task automatic wr(input int a, input int d);
    addr  = AW'(a);
    wdata = DW'(d);
    wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = AW'(a);
    #1;
    d = int'(rdata);
  endtask

  // start the generator; t = 0 is the first enabled cycle
  task automatic start(input int ctrl);
    wr(0, ctrl);
    t = 0;
  endtask

  task automatic stop();
    wr(0, 0);
    tick();
  endtask

  // line: 2 sync, 2 back, 4 active, 2 front; field0: 1,1,3,1 lines; field1: 1,2,3,1 lines
  task automatic program_default();
    wr(1, 1); wr(2, 1); wr(3, 3); wr(4, 1);
    wr(5, 0); wr(6, 0); wr(7, 2); wr(8, 0);
    wr(9, 0); wr(10, 1); wr(11, 2); wr(12, 0);
    wr(13, 0); wr(14, 1);
  endtask

  task automatic test_reset();
    int v;
    check("R10 hcnt", int'(hcnt), 0);
    check("R10 vcnt", int'(vcnt), 0);
    check("R10 field", int'(field), 0);
    check("R10 de", int'(de), 0);
    check("R10 irq", int'(irq), 0);
    rd(14, v); check("R10 status", v, 0);
    rd(0, v);  check("R10 ctrl", v, 0);
  endtask

  task automatic test_readback();
    int v;
    rd(3, v);  check("R11 hact readback", v, 3);
    rd(10, v); check("R11 f1 back readback", v, 1);
    wr(0, 4'b0110);
    rd(0, v);  check("R11 ctrl readback", v, 6);
    check("R6 disabled hcnt", int'(hcnt), 0);
    check("R4 disabled hsync inactive high", int'(hsync), 1);
    wr(0, 0);
  endtask

  task automatic test_progressive();
    int v;
    start(1);
    check("R1 hsync at pixel 0", int'(hsync), 1);
    check("R2 vsync at line 0", int'(vsync), 1);
    check("R1 hcnt start", int'(hcnt), 0);
    go_to(2);  check("R1 hsync ends after 2 pixels", int'(hsync), 0);
    go_to(9);  check("R2 vsync still on line 0", int'(vsync), 1);
    go_to(10); check("R2 vsync ends after 1 line", int'(vsync), 0);
    go_to(13); check("R1 hcnt in line 1", int'(hcnt), 3);
    check("R2 vcnt line 1", int'(vcnt), 1);
    go_to(23); check("R3 de low before active pixel", int'(de), 0);
    go_to(24); check("R3 de first active", int'(de), 1);
    go_to(27); check("R3 de last active", int'(de), 1);
    go_to(28); check("R3 de low in front porch", int'(de), 0);
    go_to(59); rd(14, v); check("R7 status clear before frame end", v, 0);
    check("R5 progressive field", int'(field), 0);
    go_to(60); check("R2 frame wraps after 6 lines", int'(vcnt), 0);
    check("R1 hcnt wraps", int'(hcnt), 0);
    check("R5 progressive field stays 0", int'(field), 0);
    rd(14, v); check("R7 status set at frame end", v, 1);
    check("R8 irq masked", int'(irq), 0);
    wr(13, 1); check("R8 irq when unmasked", int'(irq), 1);
    wr(14, 0); rd(14, v); check("R8 write zero keeps status", v, 1);
    wr(14, 1); rd(14, v); check("R8 write one clears status", v, 0);
    check("R8 irq low after clear", int'(irq), 0);
    wr(13, 0);
    stop();
  endtask

  task automatic test_interlace();
    int v;
    start(3);
    check("R5 first field is 0", int'(field), 0);
    go_to(24); check("R5 field0 de at line 2", int'(de), 1);
    go_to(59); check("R5 field0 last cycle", int'(field), 0);
    go_to(60); check("R5 field toggles to 1", int'(field), 1);
    check("R5 field1 vcnt restarts", int'(vcnt), 0);
    rd(14, v); check("R7 no status after first field", v, 0);
    go_to(84); check("R5 field1 longer back porch no de at line 2", int'(de), 0);
    go_to(93); check("R5 field1 de low before active pixel", int'(de), 0);
    go_to(94); check("R5 field1 de at line 3", int'(de), 1);
    go_to(129); check("R5 field1 lasts 7 lines", int'(field), 1);
    rd(14, v); check("R7 status clear inside field1", v, 0);
    go_to(130); check("R5 field toggles back to 0", int'(field), 0);
    rd(14, v); check("R7 status after second field", v, 1);
    stop();
    wr(14, 1);
  endtask

  task automatic test_polarity();
    start(13);
    check("R4 hsync active low", int'(hsync), 0);
    check("R4 vsync active low", int'(vsync), 0);
    go_to(2);  check("R4 hsync inactive high", int'(hsync), 1);
    go_to(10); check("R4 vsync inactive high", int'(vsync), 1);
    wr(0, 12); tick();
    check("R4 disabled low-polarity hsync", int'(hsync), 1);
    check("R4 disabled low-polarity vsync", int'(vsync), 1);
    wr(0, 0);
  endtask

  task automatic test_shadow();
    int v;
    start(1);
    go_to(4);
    wr(3, 5);
    rd(3, v); check("R11 new hact readable", v, 5);
    go_to(27); check("R9 old width in current frame", int'(de), 1);
    go_to(28); check("R9 old width ends in current frame", int'(de), 0);
    go_to(59); check("R9 old line length kept", int'(hcnt), 9);
    go_to(88); check("R9 new width in next frame", int'(de), 1);
    go_to(93); check("R9 new width last pixel", int'(de), 1);
    go_to(94); check("R9 new width ends", int'(de), 0);
    stop();
    wr(3, 3);
  endtask

  task automatic test_disable();
    start(1);
    go_to(33);
    check("R6 running hcnt", int'(hcnt), 3);
    wr(0, 0); tick();
    check("R6 hcnt zero after disable", int'(hcnt), 0);
    check("R6 vcnt zero after disable", int'(vcnt), 0);
    check("R6 de low after disable", int'(de), 0);
    repeat (5) tick();
    check("R6 counters hold while disabled", int'(hcnt), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    test_reset();
    program_default();
    test_readback();
    test_progressive();
    test_interlace();
    test_polarity();
    test_shadow();
    test_disable();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule